// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block is the sending half of a two-wire serial master. One wire is a generated serial clock. The other is a data line that the block drives. When the host raises a one-cycle start request, the block builds one command frame from the inputs presented with it. The frame can be an absolute-address read or write, a data-poll or a terminate. The block appends a 4-bit check code and shifts the frame out with the most significant bit first. A start bit goes ahead of the frame, and each bit gets exactly one period of the serial clock.

The serial clock runs at half the system clock. Each bit has one system cycle with the clock low and then one with the clock high. The data line only moves on the edge that takes the serial clock low, so it is steady when the clock rises. The line is active low: a logical 1 is driven as a low level. At the end of a frame the block raises done for one cycle. Responses from the far end are handled elsewhere, and so are retries and turning the data line around.

Top module: `cmd_frame_tx`

## Requirements
- R1: After reset and whenever idle, `sclk_o` is high. After reset `sdo_o` is high, and `busy_o`, `done_o` and `err_o` are low.
- R2: An absolute-address command (`cmd_i` = 0) sends these fields in order: slave ID (2 bits), opcode 3'b100, direction (1 = read, 0 = write), 21 address bits, a size flag, then the write bytes for writes only, then the 4-bit check code.
- R3: Size handling for absolute-address commands. With size 1 the size flag is 0 and the address is sent unchanged. With size 2 address bit 0 is sent as 0 and the flag is 1. With size 4 address bits [1:0] are sent as 2'b01 and the flag is 1.
- R4: Write bytes are sent in ascending byte order, starting with `wdata_i[7:0]`, and each byte is sent MSB first. A size-n write sends n bytes.
- R5: A data-poll command (`cmd_i` = 1) sends the slave ID, the opcode 3'b010 and the check code.
- R6: A terminate command (`cmd_i` = 2) sends the slave ID, the opcode 6'b111111 and the check code.
- R7: The start bit is a logical 1 and comes first. The check code uses the polynomial x^4+x+1 with a zero initial value and MSB-first processing. It covers the start bit and every frame bit, and it is sent MSB first after the frame bits.
- R8: The wire level is the inverse of the logical bit, so the start bit shows as a low `sdo_o` at its rising serial-clock edge.
- R9: Each bit takes exactly one serial clock period: one system cycle low, then one high. `sdo_o` changes only on the edge where `sclk_o` goes or stays low, never while `sclk_o` is high.
- R10: `busy_o` rises on the cycle after an accepted start. For a frame of N wire bits (start bit plus frame plus check code), `done_o` is high for exactly one cycle, 2N cycles after acceptance, and `busy_o` is low in that same cycle.
- R11: A start request that gives a zero-length frame is ignored and pulses `err_o` for one cycle. This covers `cmd_i` = 3, and an absolute-address command whose size is not 1, 2 or 4. The serial lines do not move and `busy_o` stays low.
- R12: A start request while `busy_o` is high is ignored. The frame in flight goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| cmd_i | input | 2 | Command type: 0 absolute address, 1 data-poll, 2 terminate, 3 reserved |
| slave_id_i | input | 2 | Target slave ID |
| addr_i | input | ADDR_W (21) | Byte address for absolute-address commands |
| size_i | input | 3 | Transfer size in bytes (1, 2 or 4) |
| read_i | input | 1 | 1 for read, 0 for write |
| wdata_i | input | 8*MAX_BYTES (32) | Write data; byte 0 is bits [7:0] |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-cycle pulse after the last check-code bit |
| err_o | output | 1 | One-cycle pulse when a zero-length request is rejected |
| sclk_o | output | 1 | Generated serial clock |
| sdo_o | output | 1 | Serial data, active low |

## Verification
The hardest situation to reach from the ports is a second start request that arrives while a frame is still being sent. It carries a different command, and it must leave the outgoing bits untouched. The stimulus raises start with a terminate command ten samples into an absolute-address write. It then checks that the captured bit stream and the done timing still match the original write. The other difficult point is the boundary between the last frame bit and the first check-code bit, where the check code must already include that last frame bit. Frames of different lengths and bit patterns are each compared bit for bit against a check code computed independently in the bench.

// File: rtl/cftx_pkg.sv
`timescale 1ns/1ps
package cftx_pkg;

  typedef enum logic [1:0] {
    CMD_ABS  = 2'b00,
    CMD_POLL = 2'b01,
    CMD_TERM = 2'b10,
    CMD_RSVD = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DATA = 2'b01,
    ST_CRC  = 2'b10
  } st_e;

  localparam logic [2:0] OPC_ABS  = 3'b100;
  localparam logic [2:0] OPC_POLL = 3'b010;
  localparam logic [5:0] OPC_TERM = 6'b111111;

  localparam int ID_W      = 2;
  localparam int POLL_BITS = ID_W + 3;
  localparam int TERM_BITS = ID_W + 6;

endpackage

// File: rtl/cftx_frame_build.sv
`timescale 1ns/1ps
module cftx_frame_build
  import cftx_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAX_BYTES = 4,
  parameter int SIZE_W    = 3,
  parameter int FRAME_W   = 60,
  parameter int LEN_W     = 6
) (
  input  logic [1:0]             cmd_i,
  input  logic [ID_W-1:0]        id_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [SIZE_W-1:0]      size_i,
  input  logic                   read_i,
  input  logic [8*MAX_BYTES-1:0] wdata_i,
  output logic [FRAME_W-1:0]     frame_o,
  output logic [LEN_W-1:0]       len_o
);

  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int HDR_W  = FRAME_W - DATA_W;

  logic [DATA_W-1:0] data_seq;
  logic [ADDR_W-1:0] addr_enc;
  logic              size_flag;
  logic              size_ok;
  logic [LEN_W-1:0]  data_len;

  // byte 0 goes first: place it in the most significant lane
  genvar b;
  generate
    for (b = 0; b < MAX_BYTES; b++) begin : g_byte
      assign data_seq[DATA_W-1-8*b -: 8] = wdata_i[8*b +: 8];
    end
  endgenerate

  always_comb begin
    size_ok = (size_i == SIZE_W'(1)) ||
              ((MAX_BYTES >= 2) && (size_i == SIZE_W'(2))) ||
              ((MAX_BYTES >= 4) && (size_i == SIZE_W'(4)));
    data_len = LEN_W'({size_i, 3'b000});
  end

  // the size is folded into the low address bits plus a flag
  always_comb begin
    addr_enc  = addr_i;
    size_flag = 1'b0;
    if (size_i == SIZE_W'(2)) begin
      addr_enc[0] = 1'b0;
      size_flag   = 1'b1;
    end else if (size_i == SIZE_W'(4)) begin
      addr_enc[1:0] = 2'b01;
      size_flag     = 1'b1;
    end
  end

  always_comb begin
    frame_o = '0;
    len_o   = '0;
    case (cmd_e'(cmd_i))
      CMD_ABS: begin
        frame_o = {id_i, OPC_ABS, read_i, addr_enc, size_flag,
                   (read_i ? {DATA_W{1'b0}} : data_seq)};
        if (size_ok) begin
          len_o = read_i ? LEN_W'(HDR_W) : (LEN_W'(HDR_W) + data_len);
        end
      end
      CMD_POLL: begin
        frame_o = {id_i, OPC_POLL, {(FRAME_W-POLL_BITS){1'b0}}};
        len_o   = LEN_W'(POLL_BITS);
      end
      CMD_TERM: begin
        frame_o = {id_i, OPC_TERM, {(FRAME_W-TERM_BITS){1'b0}}};
        len_o   = LEN_W'(TERM_BITS);
      end
      default: begin
        frame_o = '0;
        len_o   = '0;
      end
    endcase
  end

endmodule

// File: rtl/cftx_crc.sv
`timescale 1ns/1ps
module cftx_crc #(
  parameter int               CRC_W = 4,
  parameter logic [CRC_W-1:0] POLY  = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_i,
  input  logic             step_i,
  input  logic             drain_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] cur,
                                                input logic             din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? POLY : {CRC_W{1'b0}});
  endfunction

  always_comb begin
    crc_d  = crc_q;
    crc_en = seed_i | step_i | drain_i;
    if (seed_i) begin
      crc_d = crc_next({CRC_W{1'b0}}, bit_i);
    end else if (step_i) begin
      crc_d = crc_next(crc_q, bit_i);
    end else if (drain_i) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/cftx_serializer.sv
`timescale 1ns/1ps
module cftx_serializer
  import cftx_pkg::*;
#(
  parameter int FRAME_W = 60,
  parameter int LEN_W   = 6,
  parameter int CRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [CRC_W-1:0]   crc_i,
  output logic               crc_seed_o,
  output logic               crc_step_o,
  output logic               crc_drain_o,
  output logic               crc_bit_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               sclk_o,
  output logic               sdo_o
);

  localparam int CNT_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;

  st_e                st_q, st_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic [CNT_W-1:0]   ccnt_q, ccnt_d;
  logic               sclk_q, sclk_d;
  logic               sdo_q, sdo_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               sr_en, ccnt_en, line_en;

  // the serial clock register doubles as the bit phase
  always_comb begin
    st_d        = st_q;
    sr_d        = sr_q;
    rem_d       = rem_q;
    ccnt_d      = ccnt_q;
    sclk_d      = sclk_q;
    sdo_d       = sdo_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    sr_en       = 1'b0;
    ccnt_en     = 1'b0;
    line_en     = 1'b0;
    crc_seed_o  = 1'b0;
    crc_step_o  = 1'b0;
    crc_drain_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (len_i == '0) begin
            err_d = 1'b1;
          end else begin
            st_d       = ST_DATA;
            sr_d       = frame_i;
            rem_d      = len_i;
            sr_en      = 1'b1;
            sclk_d     = 1'b0;
            sdo_d      = 1'b0;
            line_en    = 1'b1;
            crc_seed_o = 1'b1;
          end
        end
      end
      ST_DATA: begin
        line_en = 1'b1;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else if (rem_q != '0) begin
          sclk_d     = 1'b0;
          sdo_d      = ~sr_q[FRAME_W-1];
          sr_d       = {sr_q[FRAME_W-2:0], 1'b0};
          rem_d      = rem_q - LEN_W'(1);
          sr_en      = 1'b1;
          crc_step_o = 1'b1;
        end else begin
          st_d        = ST_CRC;
          sclk_d      = 1'b0;
          sdo_d       = ~crc_i[CRC_W-1];
          crc_drain_o = 1'b1;
          ccnt_d      = CNT_W'(CRC_W - 1);
          ccnt_en     = 1'b1;
        end
      end
      ST_CRC: begin
        line_en = 1'b1;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else if (ccnt_q != '0) begin
          sclk_d      = 1'b0;
          sdo_d       = ~crc_i[CRC_W-1];
          crc_drain_o = 1'b1;
          ccnt_d      = ccnt_q - CNT_W'(1);
          ccnt_en     = 1'b1;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      rem_q <= '0;
    end else if (sr_en) begin
      sr_q  <= sr_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt_q <= '0;
    end else if (ccnt_en) begin
      ccnt_q <= ccnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sdo_q  <= 1'b1;
    end else if (line_en) begin
      sclk_q <= sclk_d;
      sdo_q  <= sdo_d;
    end
  end

  assign crc_bit_o = (st_q == ST_IDLE) ? 1'b1 : sr_q[FRAME_W-1];
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign sclk_o    = sclk_q;
  assign sdo_o     = sdo_q;

endmodule

// File: rtl/cmd_frame_tx.sv
`timescale 1ns/1ps
module cmd_frame_tx
  import cftx_pkg::*;
#(
  parameter int               ADDR_W    = 21,
  parameter int               MAX_BYTES = 4,
  parameter int               CRC_W     = 4,
  parameter logic [CRC_W-1:0] CRC_POLY  = 4'b0011,
  localparam int              SIZE_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [1:0]             cmd_i,
  input  logic [1:0]             slave_id_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [SIZE_W-1:0]      size_i,
  input  logic                   read_i,
  input  logic [8*MAX_BYTES-1:0] wdata_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic                   sclk_o,
  output logic                   sdo_o
);

  localparam int HDR_W   = ID_W + 3 + 1 + ADDR_W + 1;
  localparam int FRAME_W = HDR_W + 8 * MAX_BYTES;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic [CRC_W-1:0]   crc_val;
  logic               crc_seed, crc_step, crc_drain, crc_bit;

  cftx_frame_build #(
    .ADDR_W   (ADDR_W),
    .MAX_BYTES(MAX_BYTES),
    .SIZE_W   (SIZE_W),
    .FRAME_W  (FRAME_W),
    .LEN_W    (LEN_W)
  ) u_build (
    .cmd_i  (cmd_i),
    .id_i   (slave_id_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .read_i (read_i),
    .wdata_i(wdata_i),
    .frame_o(frame),
    .len_o  (frame_len)
  );

  cftx_crc #(
    .CRC_W(CRC_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed_i (crc_seed),
    .step_i (crc_step),
    .drain_i(crc_drain),
    .bit_i  (crc_bit),
    .crc_o  (crc_val)
  );

  cftx_serializer #(
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W),
    .CRC_W  (CRC_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .frame_i    (frame),
    .len_i      (frame_len),
    .crc_i      (crc_val),
    .crc_seed_o (crc_seed),
    .crc_step_o (crc_step),
    .crc_drain_o(crc_drain),
    .crc_bit_o  (crc_bit),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o)
  );

endmodule

// File: rtl/cmd_frame_tx_chk.sv
`timescale 1ns/1ps
module cmd_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic sclk_o,
  input logic sdo_o
);

  // R9
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> !sclk_o);

  // R9
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sclk_o) |=> sclk_o);

  // R1
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !$past(busy_o) && $past(start_i)));

endmodule

bind cmd_frame_tx cmd_frame_tx_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o),
  .sclk_o (sclk_o),
  .sdo_o  (sdo_o)
);

// File: tb/cmd_frame_tx_bench.sv
`timescale 1ns/1ps
module cmd_frame_tx_bench;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  cmd_i;
  logic [1:0]  slave_id_i;
  logic [20:0] addr_i;
  logic [2:0]  size_i;
  logic        read_i;
  logic [31:0] wdata_i;
  logic        busy_o, done_o, err_o, sclk_o, sdo_o;

  int checks;
  int errors;

  logic exp_bits [0:127];
  int   exp_n;

  cmd_frame_tx u_cmd_frame_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmd_i     (cmd_i),
    .slave_id_i(slave_id_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .read_i    (read_i),
    .wdata_i   (wdata_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_bits[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic build_exp(input logic [1:0] cmd, input logic [1:0] id,
                           input logic [20:0] addr, input logic [2:0] size,
                           input logic rd, input logic [31:0] wd);
    logic [20:0] a;
    logic [3:0]  c;
    logic        fb;
    int          n;
    exp_n = 0;
    push(64'd1, 1);
    push({62'd0, id}, 2);
    if (cmd == 2'd0) begin
      push(64'b100, 3);
      push({63'd0, rd}, 1);
      a = addr;
      if (size == 3'd2) a[0] = 1'b0;
      if (size == 3'd4) a[1:0] = 2'b01;
      push({43'd0, a}, 21);
      push({63'd0, (size != 3'd1)}, 1);
      if (!rd) begin
        for (int i = 0; i < int'(size); i++) push({56'd0, wd[8*i +: 8]}, 8);
      end
    end else if (cmd == 2'd1) begin
      push(64'b010, 3);
    end else begin
      push(64'h3f, 6);
    end
    c = 4'd0;
    n = exp_n;
    for (int i = 0; i < n; i++) begin
      fb = c[3] ^ exp_bits[i];
      c  = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    push({60'd0, c}, 4);
  endtask

  task automatic run_frame(input logic [1:0] cmd, input logic [1:0] id,
                           input logic [20:0] addr, input logic [2:0] size,
                           input logic rd, input logic [31:0] wd,
                           input bit poke, input string tag);
    logic cap [0:127];
    int   cap_n;
    int   s;
    int   mism;
    logic prev, lowval, first_raw;
    bit   bad_hold, seen;
    build_exp(cmd, id, addr, size, rd, wd);
    @(negedge clk);
    cmd_i = cmd; slave_id_i = id; addr_i = addr; size_i = size;
    read_i = rd; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R10 busy after start ", tag}, busy_o, 1);
    s = 1; prev = 1'b1; lowval = 1'b1; cap_n = 0; bad_hold = 0; seen = 0;
    first_raw = 1'b1;
    while (s < 600) begin
      if (poke && s == 10) begin start_i = 1'b1; cmd_i = 2'd2; end
      if (poke && s == 11) start_i = 1'b0;
      if (sclk_o && !prev && cap_n < 128) begin
        if (cap_n == 0) first_raw = sdo_o;
        cap[cap_n] = ~sdo_o;
        if (sdo_o !== lowval) bad_hold = 1;
        cap_n++;
      end
      if (!sclk_o) lowval = sdo_o;
      prev = sclk_o;
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
      s++;
    end
    chk(seen, {"R10 done seen ", tag}, seen, 1);
    chk(cap_n == exp_n, {"R9 bit count ", tag}, cap_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (mism < 0 && cap[i] !== exp_bits[i]) mism = i;
    end
    chk(mism < 0, {tag, " frame bits (first mismatch index)"}, mism, -1);
    chk(first_raw == 1'b0, {"R8 start bit low on wire ", tag}, first_raw, 0);
    chk(!bad_hold, {"R9 data stable at rising clock ", tag}, bad_hold, 0);
    chk(s == 2 * exp_n + 1, {"R10 done timing ", tag}, s, 2 * exp_n + 1);
    @(negedge clk);
    chk(!done_o && !busy_o && sclk_o, {"R10 single done pulse ", tag},
        {done_o, busy_o, sclk_o}, 3'b001);
  endtask

  task automatic run_reject(input logic [1:0] cmd, input logic [2:0] size,
                            input string tag);
    logic sdo_before;
    @(negedge clk);
    sdo_before = sdo_o;
    cmd_i = cmd; size_i = size; read_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o && !busy_o, {"R11 err pulse ", tag}, {err_o, busy_o}, 2'b10);
    @(negedge clk);
    chk(!err_o && !busy_o && sclk_o && (sdo_o == sdo_before),
        {"R11 request ignored ", tag},
        {err_o, busy_o, sclk_o, sdo_o}, {3'b001, sdo_before});
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    start_i = 1'b0; cmd_i = 2'd0; slave_id_i = 2'd0; addr_i = '0;
    size_i = 3'd1; read_i = 1'b0; wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(sclk_o && sdo_o && !busy_o && !done_o && !err_o, "R1 reset state",
        {sclk_o, sdo_o, busy_o, done_o, err_o}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk_o && sdo_o && !busy_o, "R1 idle after release",
        {sclk_o, sdo_o, busy_o}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    test_reset();
    run_frame(2'd0, 2'd2, 21'h1ABCDE, 3'd1, 1'b1, 32'h0, 0, "R2 R7 abs read size1");
    run_frame(2'd0, 2'd1, 21'h0F0F0F, 3'd4, 1'b0, 32'hA1B2C3D4, 0, "R3 R4 abs write size4");
    run_frame(2'd0, 2'd3, 21'h0ABCD3, 3'd2, 1'b0, 32'h00005A3C, 0, "R3 R4 abs write size2");
    run_frame(2'd0, 2'd0, 21'h1FFFFE, 3'd4, 1'b1, 32'h0, 0, "R3 abs read size4");
    run_frame(2'd1, 2'd1, 21'h0, 3'd1, 1'b0, 32'h0, 0, "R5 data-poll");
    run_frame(2'd2, 2'd2, 21'h0, 3'd1, 1'b0, 32'h0, 0, "R6 terminate");
    run_reject(2'd3, 3'd1, "reserved command");
    run_reject(2'd0, 3'd3, "abs size 3");
    run_reject(2'd0, 3'd0, "abs size 0");
    run_frame(2'd0, 2'd1, 21'h12345, 3'd1, 1'b0, 32'h000000C7, 1, "R12 start while busy");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule